// File: doc/BRIEF.md
# Bank-Affinity Patch Scheduler

This block places the slices of a batched tensor ("patches") onto compute clusters so that each patch is worked on by a cluster sitting close to the memory bank that holds it. Every memory bank owns a fixed group of near clusters. A scheduling pass opens with a start pulse that carries the number of patches N. Patch descriptors then arrive one per valid/ready handshake. Each descriptor carries a patch identifier, one presence bit per bank, an overlap flag, a share value per bank and geometry coordinates.

Each descriptor is first resolved to a single home bank. A patch that straddles banks goes to the bank holding the largest share of it, and a pseudo-random generator breaks ties. Within the home bank's group, patches are dealt to the clusters in rotating order. Each placement is appended to a mapping register file that holds the patch identifier and geometry. A cluster CPU selects its cluster index and a slot number to read its list of patches, and reads a per-cluster count to know how many entries are valid. A one-cycle done pulse closes the pass.

Top module: `bank_affinity_sched`

## Requirements
- R1: After reset, desc_ready and done are low, and every cluster's rd_count reads 0.
- R2: A start pulse seen while idle opens a pass. desc_ready goes high from the next cycle until the N-th descriptor is accepted. A start pulse during a pass is ignored. A num_patches value above MAX_PATCHES is treated as MAX_PATCHES.
- R3: When desc_overlap is 0, the home bank is the lowest-numbered bank whose presence bit is set. A descriptor with no presence bit set goes to bank 0 whatever its overlap flag.
- R4: When desc_overlap is 1, the home bank is the present bank with the largest share. Bank b's share is desc_share[b*SHARE_W +: SHARE_W]. The shares of banks whose presence bit is 0 have no effect.
- R5: Ties in R4 are broken with a 16-bit LFSR seeded with LFSR_SEED at reset. The LFSR shifts left with feedback equal to the XOR of bits 15, 13, 12 and 10, and steps once per accepted descriptor. Its value before the step, taken modulo NUM_BANKS, gives the start bank of an upward cyclic scan. The first tied bank found by the scan wins.
- R6: Bank b owns clusters b*CLUSTERS_PER_BANK up to b*CLUSTERS_PER_BANK+CLUSTERS_PER_BANK-1. Successive patches homed to bank b go to these clusters in rising order, wrapping around. Each bank's rotation restarts at its first cluster on every pass.
- R7: Slot s of cluster c holds the identifier and geometry of the (s+1)-th patch dealt to c in the current pass. rd_count gives the number of patches dealt to c. Slots at or above the count read as zero.
- R8: done is high for exactly one cycle, the cycle after the N-th accept. desc_ready is low in that cycle. With N equal to 0, done is high in the cycle after the start pulse and no descriptor is accepted.
- R9: At the end of a pass, the rd_count values of all clusters sum to the effective N.
- R10: A start pulse accepted while idle clears every cluster count and every rotation pointer, even when N is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens a scheduling pass |
| num_patches | input | NP_W | Patch count N for the pass |
| desc_valid | input | 1 | Descriptor valid |
| desc_ready | output | 1 | Descriptor accepted when high with valid |
| desc_patch | input | PIDX_W | Patch identifier |
| desc_present | input | NUM_BANKS | One presence bit per bank |
| desc_overlap | input | 1 | Patch spans more than one bank |
| desc_share | input | NUM_BANKS*SHARE_W | Per-bank share of the patch |
| desc_geom | input | GEOM_W | Geometry coordinates |
| done | output | 1 | Pass complete pulse |
| rd_cluster | input | CL_W | Cluster index for reading |
| rd_slot | input | SLOT_W | Slot index for reading |
| rd_count | output | CNT_W | Patches dealt to rd_cluster |
| rd_patch | output | PIDX_W | Patch identifier in the selected slot |
| rd_geom | output | GEOM_W | Geometry in the selected slot |

## Verification
A wrong home bank or a slipped rotation pointer moves one patch into the wrong cluster. That shows up at the end of the same pass as a count off by one in two clusters and a shifted slot list. A desynchronised LFSR only shows up at the next tied patch, so the bench drives all-equal shares in a dedicated pass and uses small share values in its random passes to make ties frequent. A bad handshake or pass counter shows at once as a missing or early done pulse, or as desc_ready staying high.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} sched_state_e;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/bas_lfsr.sv
module bas_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        arst_n,
  input  logic        step,
  output logic [15:0] value
);
  import bas_pkg::*;

  logic [LFSR_W-1:0] q, d;

  always_comb begin
    d = q;
    if (step) d = {q[LFSR_W-2:0], ^(q & LFSR_TAPS)};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= SEED;
    else if (step) q <= d;
  end

  assign value = q;

  p_lfsr_live_r5: assert property (@(posedge clk) disable iff (!arst_n) q != '0)
    else $error("LFSR reached the all-zero lock state");
endmodule

// File: rtl/bas_home_resolver.sv
module bas_home_resolver #(
  parameter int NUM_BANKS = 4,
  parameter int SHARE_W   = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic [NUM_BANKS-1:0]         present,
  input  logic                         overlap,
  input  logic [NUM_BANKS*SHARE_W-1:0] shares,
  input  logic [BANK_W-1:0]            rot,
  output logic [BANK_W-1:0]            home
);
  logic [SHARE_W-1:0]   best;
  logic [NUM_BANKS-1:0] tied;
  logic [BANK_W-1:0]    lowest;
  logic [BANK_W-1:0]    picked;
  logic                 found;

  // lowest present bank for single-bank patches
  always_comb begin
    lowest = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (present[b]) lowest = BANK_W'(b);
    end
  end

  // largest share among present banks
  always_comb begin
    best = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (present[b] && shares[b*SHARE_W +: SHARE_W] > best)
        best = shares[b*SHARE_W +: SHARE_W];
    end
  end

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_tie
      assign tied[g] = present[g] && (shares[g*SHARE_W +: SHARE_W] == best);
    end
  endgenerate

  // cyclic scan from the random start bank
  always_comb begin
    picked = '0;
    found  = 1'b0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (!found && tied[BANK_W'(int'(rot) + k)]) begin
        picked = BANK_W'(int'(rot) + k);
        found  = 1'b1;
      end
    end
  end

  assign home = overlap ? picked : lowest;
endmodule

// File: rtl/bas_deal.sv
module bas_deal #(
  parameter int NUM_BANKS         = 4,
  parameter int CLUSTERS_PER_BANK = 2,
  parameter int SLOTS             = 8,
  parameter int PIDX_W            = 8,
  parameter int GEOM_W            = 16,
  localparam int NUM_CL = NUM_BANKS * CLUSTERS_PER_BANK,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int CL_W   = $clog2(NUM_CL),
  localparam int CPB_W  = (CLUSTERS_PER_BANK > 1) ? $clog2(CLUSTERS_PER_BANK) : 1,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              clear,
  input  logic              wr,
  input  logic [BANK_W-1:0] home,
  input  logic [PIDX_W-1:0] pidx,
  input  logic [GEOM_W-1:0] geom,
  input  logic [CL_W-1:0]   rd_cluster,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [CNT_W-1:0]  rd_count,
  output logic [PIDX_W-1:0] rd_patch,
  output logic [GEOM_W-1:0] rd_geom
);
  logic [CPB_W-1:0]  ptr_q [NUM_BANKS];
  logic [CPB_W-1:0]  ptr_d [NUM_BANKS];
  logic [CNT_W-1:0]  cnt_q [NUM_CL];
  logic [CNT_W-1:0]  cnt_d [NUM_CL];
  logic [PIDX_W-1:0] mem_pidx [NUM_CL][SLOTS];
  logic [GEOM_W-1:0] mem_geom [NUM_CL][SLOTS];
  logic [CL_W-1:0]   sel;
  logic              mem_we;
  logic [CNT_W+CL_W:0] total;

  assign sel    = CL_W'(int'(home) * CLUSTERS_PER_BANK + int'(ptr_q[home]));
  assign mem_we = wr && !clear && (int'(cnt_q[sel]) < SLOTS);

  always_comb begin
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (clear) begin
      for (int b = 0; b < NUM_BANKS; b++) ptr_d[b] = '0;
      for (int c = 0; c < NUM_CL; c++) cnt_d[c] = '0;
    end else if (wr) begin
      if (int'(ptr_q[home]) == CLUSTERS_PER_BANK - 1) ptr_d[home] = '0;
      else ptr_d[home] = ptr_q[home] + 1'b1;
      cnt_d[sel] = cnt_q[sel] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) ptr_q[b] <= '0;
      for (int c = 0; c < NUM_CL; c++) cnt_q[c] <= '0;
    end else if (clear || wr) begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset; the per-cluster count qualifies every read
  always_ff @(posedge clk) begin
    if (mem_we) begin
      mem_pidx[sel][SLOT_W'(cnt_q[sel])] <= pidx;
      mem_geom[sel][SLOT_W'(cnt_q[sel])] <= geom;
    end
  end

  always_comb begin
    rd_count = cnt_q[rd_cluster];
    rd_patch = '0;
    rd_geom  = '0;
    if (CNT_W'(rd_slot) < cnt_q[rd_cluster]) begin
      rd_patch = mem_pidx[rd_cluster][rd_slot];
      rd_geom  = mem_geom[rd_cluster][rd_slot];
    end
  end

  always_comb begin
    total = '0;
    for (int c = 0; c < NUM_CL; c++) total = total + (CNT_W+CL_W+1)'(cnt_q[c]);
  end

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_ptr_chk
      p_ptr_range_r6: assert property (@(posedge clk) disable iff (!arst_n)
        int'(ptr_q[g]) < CLUSTERS_PER_BANK)
        else $error("rotation pointer of bank %0d out of its group", g);
    end
  endgenerate

  p_slot_room_r7: assert property (@(posedge clk) disable iff (!arst_n)
    (wr && !clear) |-> (int'(cnt_q[sel]) < SLOTS))
    else $error("cluster slot list overflow");

  p_total_step_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (wr && !clear) |=> (total == $past(total) + 1'b1))
    else $error("cluster counts did not grow by one on a placement");

  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!arst_n)
    clear |=> (total == '0))
    else $error("counts not cleared at pass start");
endmodule

// File: rtl/bank_affinity_sched.sv
module bank_affinity_sched #(
  parameter int NUM_BANKS         = 4,
  parameter int CLUSTERS_PER_BANK = 2,
  parameter int MAX_PATCHES       = 16,
  parameter int PIDX_W            = 8,
  parameter int GEOM_W            = 16,
  parameter int SHARE_W           = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int NUM_CL = NUM_BANKS * CLUSTERS_PER_BANK,
  localparam int SLOTS  = (MAX_PATCHES + CLUSTERS_PER_BANK - 1) / CLUSTERS_PER_BANK,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int CL_W   = $clog2(NUM_CL),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int NP_W   = $clog2(MAX_PATCHES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [NP_W-1:0]              num_patches,
  input  logic                         desc_valid,
  output logic                         desc_ready,
  input  logic [PIDX_W-1:0]            desc_patch,
  input  logic [NUM_BANKS-1:0]         desc_present,
  input  logic                         desc_overlap,
  input  logic [NUM_BANKS*SHARE_W-1:0] desc_share,
  input  logic [GEOM_W-1:0]            desc_geom,
  output logic                         done,
  input  logic [CL_W-1:0]              rd_cluster,
  input  logic [SLOT_W-1:0]            rd_slot,
  output logic [CNT_W-1:0]             rd_count,
  output logic [PIDX_W-1:0]            rd_patch,
  output logic [GEOM_W-1:0]            rd_geom
);
  import bas_pkg::*;

  logic [1:0]        rst_sync;
  logic              arst_n;
  sched_state_e      state_q, state_d;
  logic [NP_W-1:0]   left_q, left_d;
  logic              done_q, done_d;
  logic [NP_W-1:0]   n_eff;
  logic              start_go;
  logic              accept;
  logic [15:0]       lfsr_val;
  logic [BANK_W-1:0] home;
  logic              home_beaten;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign arst_n = rst_sync[1];

  assign n_eff      = (int'(num_patches) > MAX_PATCHES) ? NP_W'(MAX_PATCHES) : num_patches;
  assign desc_ready = (state_q == ST_RUN);
  assign accept     = desc_valid && desc_ready;
  assign start_go   = start && (state_q == ST_IDLE);
  assign done       = done_q;

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    done_d  = 1'b0;
    if (start_go) begin
      if (n_eff == '0) begin
        done_d = 1'b1;
      end else begin
        state_d = ST_RUN;
        left_d  = n_eff;
      end
    end else if (accept) begin
      left_d = left_q - 1'b1;
      if (left_q == NP_W'(1)) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (start_go || accept) left_q <= left_d;
    end
  end

  bas_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk    (clk),
    .arst_n (arst_n),
    .step   (accept),
    .value  (lfsr_val)
  );

  bas_home_resolver #(.NUM_BANKS(NUM_BANKS), .SHARE_W(SHARE_W)) u_resolve (
    .present (desc_present),
    .overlap (desc_overlap),
    .shares  (desc_share),
    .rot     (lfsr_val[BANK_W-1:0]),
    .home    (home)
  );

  bas_deal #(
    .NUM_BANKS         (NUM_BANKS),
    .CLUSTERS_PER_BANK (CLUSTERS_PER_BANK),
    .SLOTS             (SLOTS),
    .PIDX_W            (PIDX_W),
    .GEOM_W            (GEOM_W)
  ) u_deal (
    .clk        (clk),
    .arst_n     (arst_n),
    .clear      (start_go),
    .wr         (accept),
    .home       (home),
    .pidx       (desc_patch),
    .geom       (desc_geom),
    .rd_cluster (rd_cluster),
    .rd_slot    (rd_slot),
    .rd_count   (rd_count),
    .rd_patch   (rd_patch),
    .rd_geom    (rd_geom)
  );

  // independent check that no present bank beats the chosen one
  always_comb begin
    home_beaten = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (desc_present[b] &&
          desc_share[b*SHARE_W +: SHARE_W] > desc_share[int'(home)*SHARE_W +: SHARE_W])
        home_beaten = 1'b1;
    end
  end

  p_home_present_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (accept && (|desc_present)) |-> desc_present[home])
    else $error("patch homed to a bank that does not hold it");

  p_empty_bank0_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (accept && !(|desc_present)) |-> (home == '0))
    else $error("patch with no presence bit not homed to bank 0");

  p_share_max_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (accept && desc_overlap) |-> !home_beaten)
    else $error("overlapped patch not homed to its largest share");

  p_ready_after_start_r2: assert property (@(posedge clk) disable iff (!arst_n)
    (start_go && n_eff != '0) |=> desc_ready)
    else $error("pass did not open after start");

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!arst_n)
    done |-> !desc_ready)
    else $error("done raised while still taking descriptors");
endmodule

// File: tb/test_bank_affinity_sched.sv
module test_bank_affinity_sched;
  localparam int NB = 4, CPB = 2, NC = 8, SL = 8, MAXP = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  num_patches = '0;
  logic        desc_valid = 1'b0;
  logic        desc_ready;
  logic [7:0]  desc_patch = '0;
  logic [3:0]  desc_present = '0;
  logic        desc_overlap = 1'b0;
  logic [31:0] desc_share = '0;
  logic [15:0] desc_geom = '0;
  logic        done;
  logic [2:0]  rd_cluster = '0;
  logic [2:0]  rd_slot = '0;
  logic [3:0]  rd_count;
  logic [7:0]  rd_patch;
  logic [15:0] rd_geom;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int exp_cnt [NC];
  int exp_pidx [NC][SL];
  int exp_geom [NC][SL];
  int ptr [NB];
  logic [15:0] mlfsr = 16'hACE1;

  always #10 clk = ~clk;

  bank_affinity_sched i_bank_affinity_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .num_patches(num_patches),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_patch(desc_patch),
    .desc_present(desc_present), .desc_overlap(desc_overlap), .desc_share(desc_share),
    .desc_geom(desc_geom), .done(done), .rd_cluster(rd_cluster), .rd_slot(rd_slot),
    .rd_count(rd_count), .rd_patch(rd_patch), .rd_geom(rd_geom)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic int model_home(input logic [3:0] pr, input logic ov,
                                    input logic [31:0] sh, input logic [15:0] lf);
    int best = -1;
    int rot = int'(lf[1:0]);
    if (pr == 4'b0) return 0;
    if (!ov) begin
      for (int b = 0; b < NB; b++) if (pr[b]) return b;
    end
    for (int b = 0; b < NB; b++)
      if (pr[b] && int'(sh[b*8 +: 8]) > best) best = int'(sh[b*8 +: 8]);
    for (int k = 0; k < NB; k++) begin
      int b = (rot + k) % NB;
      if (pr[b] && int'(sh[b*8 +: 8]) == best) return b;
    end
    return 0;
  endfunction

  task automatic model_clear();
    for (int c = 0; c < NC; c++) exp_cnt[c] = 0;
    for (int b = 0; b < NB; b++) ptr[b] = 0;
  endtask

  task automatic verify_all(input string tag);
    int sum = 0;
    for (int c = 0; c < NC; c++) begin
      @(negedge clk);
      rd_cluster = 3'(c);
      rd_slot = '0;
      #1;
      chk(int'(rd_count) == exp_cnt[c], tag, "R7 cluster count", int'(rd_count), exp_cnt[c]);
      sum += int'(rd_count);
      for (int s = 0; s < SL; s++) begin
        int ep = (s < exp_cnt[c]) ? exp_pidx[c][s] : 0;
        int eg = (s < exp_cnt[c]) ? exp_geom[c][s] : 0;
        rd_slot = 3'(s);
        #1;
        chk(int'(rd_patch) == ep, tag, "R6 R7 slot patch", int'(rd_patch), ep);
        chk(int'(rd_geom) == eg, tag, "R7 slot geometry", int'(rd_geom), eg);
      end
    end
    chk(sum == sum_exp(), tag, "R9 count sum", sum, sum_exp());
  endtask

  function automatic int sum_exp();
    int s = 0;
    for (int c = 0; c < NC; c++) s += exp_cnt[c];
    return s;
  endfunction

  // mode: 0 random, 1 single bank + mid-pass start, 2 full ties,
  //       3 absent banks with big shares, 4 no presence, 5 single-bank multi-present
  task automatic run_pass(input int n_req, input int mode, input string tag);
    int eff = (n_req > MAXP) ? MAXP : n_req;
    logic [3:0] pr;
    logic ov;
    logic [31:0] sh;
    model_clear();
    @(negedge clk);
    start = 1'b1;
    num_patches = 5'(n_req);
    @(negedge clk);
    start = 1'b0;
    if (eff == 0) begin
      chk(done == 1'b1, tag, "R8 done after empty pass", int'(done), 1);
      chk(desc_ready == 1'b0, tag, "R8 ready with empty pass", int'(desc_ready), 0);
      @(negedge clk);
      chk(done == 1'b0, tag, "R8 done pulse width", int'(done), 0);
      verify_all(tag);
      return;
    end
    chk(desc_ready == 1'b1, tag, "R2 ready after start", int'(desc_ready), 1);
    for (int i = 0; i < eff; i++) begin
      start = 1'b0;
      if (mode == 0 && ($urandom % 4) == 0) begin
        desc_valid = 1'b0;
        @(negedge clk);
      end
      case (mode)
        1: begin pr = 4'b0001; ov = 1'b0; sh = $urandom; end
        2: begin pr = 4'b1111; ov = 1'b1; sh = {4{8'd5}}; end
        3: begin
             pr = 4'($urandom) | 4'b0010;
             ov = 1'b1;
             for (int b = 0; b < NB; b++)
               sh[b*8 +: 8] = pr[b] ? 8'($urandom % 200) : 8'd255;
           end
        4: begin pr = 4'b0000; ov = 1'($urandom); sh = $urandom; end
        5: begin pr = 4'($urandom) | 4'b1000; ov = 1'b0; sh = $urandom; end
        default: begin
             pr = 4'($urandom);
             ov = 1'($urandom);
             for (int b = 0; b < NB; b++) sh[b*8 +: 8] = 8'($urandom % 4);
           end
      endcase
      if (mode == 1 && i == 3) begin
        start = 1'b1;
        num_patches = 5'd3;
      end
      desc_valid = 1'b1;
      desc_present = pr;
      desc_overlap = ov;
      desc_share = sh;
      desc_patch = 8'($urandom);
      desc_geom = 16'($urandom);
      @(posedge clk);
      begin
        int h = model_home(pr, ov, sh, mlfsr);
        int cl = h * CPB + ptr[h];
        mlfsr = lfsr_step(mlfsr);
        exp_pidx[cl][exp_cnt[cl]] = int'(desc_patch);
        exp_geom[cl][exp_cnt[cl]] = int'(desc_geom);
        exp_cnt[cl]++;
        ptr[h] = (ptr[h] + 1) % CPB;
      end
      @(negedge clk);
      if (i < eff - 1 && i == 0)
        chk(desc_ready == 1'b1, tag, "R2 ready during pass", int'(desc_ready), 1);
    end
    start = 1'b0;
    desc_valid = 1'b0;
    chk(done == 1'b1, tag, "R8 done after last accept", int'(done), 1);
    chk(desc_ready == 1'b0, tag, "R2 ready drops after N", int'(desc_ready), 0);
    @(negedge clk);
    chk(done == 1'b0, tag, "R8 done pulse width", int'(done), 0);
    verify_all(tag);
  endtask

  initial begin
    #(64'd20 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(desc_ready == 1'b0, "R1", "ready after reset", int'(desc_ready), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    for (int c = 0; c < NC; c++) begin
      rd_cluster = 3'(c);
      #1;
      chk(rd_count == '0, "R1", "count after reset", int'(rd_count), 0);
    end
    run_pass(16, 1, "R6 wrap and R2 ignored start");
    run_pass(12, 2, "R5 ties");
    run_pass(10, 3, "R4 absent shares");
    run_pass(6, 4, "R3 no presence");
    run_pass(8, 5, "R3 lowest present");
    run_pass(0, 0, "R10 empty pass clears");
    run_pass(20, 0, "R2 clamp");
    for (int p = 0; p < 6; p++) run_pass(1 + int'($urandom % MAXP), 0, "R4 R5 random");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule